// File: doc/BRIEF.md
# Register Window Controller

This block tracks a sliding window of sixteen visible registers over a larger physical register file. It holds three pieces of state. The first is a base pointer that counts in four-register frames. The second is a start bitmap that marks which frames begin a live call frame. The third is a saved copy of the base, which trap handlers use. Each accepted operation strobe selects one of the window operations: call entry, windowed return, relative rotate, restore of the saved base, or the stack-move check. In the same cycle the block shows the base it will take next. If the operation cannot complete, it also shows a trap request.

Trap handlers spill or refill frames and then acknowledge. Until that acknowledge arrives, the block accepts no further operations. The register storage, the handlers and the spill traffic sit outside the block. It only decides which rotation happens, which bitmap bit changes and which trap is raised.

Top module: `regwin_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the base and saved base are 0, the start bitmap has only frame 0 set, the block is not busy and no trap is shown.
- R2: All base arithmetic wraps modulo the frame count (registers / 4). For example, rotating base 3 by -5 in a 16-frame file gives 14.
- R3: Entry (op code 1) is illegal when the operand field is above 3, or when the windowing mode check fails. That check passes only with the overflow-enable input at 1 and the exception-mode input at 0. An illegal entry raises trap kind 7 and changes no state.
- R4: A legal entry whose call increment c (0..3) finds no start bit set in frames base+1 .. base+c moves the base to base+c. It also sets the start bit of the new base.
- R5: Otherwise, let k be the nearest set frame ahead (base+k, k ≥ 1). The base moves to base+k, the old base is saved and no start bit changes. The trap kind is 1 (4-register overflow) when frame base+k+1 is set, 2 (8-register) when only base+k+2 is set, and 3 (12-register) when neither is set.
- R6: Return (op code 2) takes n from bits 31:30 of the return-address input. m is the distance 1, 2 or 3 of the nearest set frame below the base, or 0 if none is set. The return is illegal, raising kind 7 with no state change, when n = 0, when m ≠ 0 and m ≠ n, or when the mode check of R3 fails.
- R7: During a legal return, the return PC output carries bits 31:30 of the PC input and bits 29:0 of the return-address input.
- R8: A legal return moves the base to base−n. If the start bit of that new base is set, it clears the start bit of the old base.
- R9: If that bit is clear, the base still moves to base−n. The old base is saved, the bitmap is unchanged, and the trap kind is 3+n (4, 5, 6 for 4-, 8- and 12-register underflow).
- R10: Rotate (op code 3) adds the 4-bit operand, read as two's complement (−8..7), to the base.
- R11: Restore (op code 4) loads the base from the saved base.
- R12: The stack-move check (op code 5) raises trap kind 8 when none of frames base−1, base−2, base−3 is set. It never changes state.
- R13: Trap and next base appear combinationally in the cycle of the accepted strobe, and state updates at that clock edge. After any trap the block is busy. While busy it ignores strobes, with no trap and no state change. An acknowledge clears busy at the next edge. Op codes 0, 6 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid_i | input | 1 | Operation strobe |
| op_code_i | input | 3 | Operation select (1 entry, 2 return, 3 rotate, 4 restore, 5 stack-move check) |
| op_imm_i | input | 4 | Entry register operand, or signed rotate amount |
| callinc_i | input | 2 | Call increment for entry |
| woe_i | input | 1 | Window overflow enable |
| excm_i | input | 1 | Exception mode active |
| ra_i | input | 32 | Return-address register contents |
| pc_i | input | 32 | PC of the operation |
| trap_ack_i | input | 1 | Trap handler done |
| busy_o | output | 1 | Trap outstanding, strobes ignored |
| base_o | output | BW | Current window base |
| base_next_o | output | BW | Base after this cycle's operation |
| saved_base_o | output | BW | Base saved by the last overflow or underflow |
| start_o | output | FRAMES | Window start bitmap |
| trap_o | output | 1 | Trap request for this strobe |
| trap_kind_o | output | 4 | Trap kind code (see R3, R5, R9, R12) |
| ret_pc_o | output | 32 | Return PC for a return operation |

## Verification
The bound checker watches the cycle-level rules on every cycle. These are: busy blocks all state change, every trap is followed by busy, the base lands where next-base pointed, the saved base captures the old base on overflow and underflow, an illegal operation leaves state alone, the bitmap never empties, and the return PC is spliced correctly. Some checks only the bench's reference model can make. These cover the choice between 4-, 8- and 12-register traps, the legality decision from n and m, the wrap of the base at the file edge and the exact bitmap contents. The model replays directed sequences and a long random stream of mixed operations and acknowledges.

// File: rtl/regwin_pkg.sv
// Shared encodings for the register window controller.
package regwin_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ENTRY   = 3'd1,
        OP_RETW    = 3'd2,
        OP_ROTATE  = 3'd3,
        OP_RESTORE = 3'd4,
        OP_MOVSP   = 3'd5
    } win_op_e;

    typedef enum logic [3:0] {
        TK_NONE    = 4'd0,
        TK_OVF4    = 4'd1,
        TK_OVF8    = 4'd2,
        TK_OVF12   = 4'd3,
        TK_UNF4    = 4'd4,
        TK_UNF8    = 4'd5,
        TK_UNF12   = 4'd6,
        TK_ILLEGAL = 4'd7,
        TK_ALLOCA  = 4'd8
    } trap_kind_e;

endpackage

// File: rtl/regwin_scan.sv
// Picks the start bits around the base: five frames ahead and three behind.
// Assumes FRAMES is a power of two, so base arithmetic wraps by truncation.
module regwin_scan #(
    parameter int FRAMES = 16,
    localparam int BW    = $clog2(FRAMES)
) (
    input  logic [FRAMES-1:0] start_i,
    input  logic [BW-1:0]     base_i,
    output logic [4:0]        ahead_o,   // ahead_o[i] = start[base+1+i]
    output logic [2:0]        behind_o   // behind_o[j] = start[base-1-j]
);

    // Frames in front of the base, nearest first.
    for (genvar i = 0; i < 5; i++) begin : g_ahead
        localparam logic [BW-1:0] OFF = BW'(i + 1);
        assign ahead_o[i] = start_i[base_i + OFF];
    end

    // Frames behind the base, nearest first.
    for (genvar j = 0; j < 3; j++) begin : g_behind
        localparam logic [BW-1:0] OFF = BW'(j + 1);
        assign behind_o[j] = start_i[base_i - OFF];
    end

endmodule

// File: rtl/regwin_decide.sv
// Combinational decision for one accepted operation.
// Produces the next base, the bitmap edits, the save request and the trap.
// Assumes op_go_i is already gated by the busy state.
module regwin_decide
    import regwin_pkg::*;
#(
    parameter int FRAMES = 16,
    localparam int BW    = $clog2(FRAMES)
) (
    input  logic          op_go_i,
    input  logic [2:0]    op_code_i,
    input  logic [3:0]    op_imm_i,
    input  logic [1:0]    callinc_i,
    input  logic          woe_i,
    input  logic          excm_i,
    input  logic [31:0]   ra_i,
    input  logic [31:0]   pc_i,
    input  logic [BW-1:0] base_i,
    input  logic [BW-1:0] saved_i,
    input  logic [4:0]    ahead_i,
    input  logic [2:0]    behind_i,
    output logic [BW-1:0] base_nxt_o,
    output logic          set_new_o,
    output logic          clr_old_o,
    output logic          save_o,
    output logic          trap_o,
    output trap_kind_e    kind_o,
    output logic [31:0]   ret_pc_o
);

    logic        mode_ok;
    logic [2:0]  inc_mask;
    logic [1:0]  first_ahead;
    logic [2:0]  hop;
    logic [1:0]  ret_n;
    logic [1:0]  ret_m;
    logic [31:0] rot_ext;

    // Helper terms shared by several operations.
    always_comb begin
        mode_ok     = woe_i & ~excm_i;
        inc_mask    = 3'((4'd1 << callinc_i) - 4'd1);
        first_ahead = ahead_i[0] ? 2'd0 : (ahead_i[1] ? 2'd1 : 2'd2);
        hop         = {1'b0, first_ahead} + 3'd1;
        ret_n       = ra_i[31:30];
        ret_m       = behind_i[0] ? 2'd1 : (behind_i[1] ? 2'd2 :
                      (behind_i[2] ? 2'd3 : 2'd0));
        rot_ext     = {{28{op_imm_i[3]}}, op_imm_i};
        ret_pc_o    = {pc_i[31:30], ra_i[29:0]};
    end

    // Operation decode: next base, bitmap edits and trap choice.
    always_comb begin
        base_nxt_o = base_i;
        set_new_o  = 1'b0;
        clr_old_o  = 1'b0;
        save_o     = 1'b0;
        trap_o     = 1'b0;
        kind_o     = TK_NONE;
        if (op_go_i) begin
            case (win_op_e'(op_code_i))
                OP_ENTRY: begin
                    if (op_imm_i > 4'd3 || !mode_ok) begin
                        trap_o = 1'b1;
                        kind_o = TK_ILLEGAL;
                    end else if (|(ahead_i[2:0] & inc_mask)) begin
                        base_nxt_o = base_i + BW'(hop);
                        save_o     = 1'b1;
                        trap_o     = 1'b1;
                        if (ahead_i[hop])
                            kind_o = TK_OVF4;
                        else if (ahead_i[hop + 3'd1])
                            kind_o = TK_OVF8;
                        else
                            kind_o = TK_OVF12;
                    end else begin
                        base_nxt_o = base_i + BW'(callinc_i);
                        set_new_o  = 1'b1;
                    end
                end
                OP_RETW: begin
                    if (ret_n == 2'd0 || (ret_m != 2'd0 && ret_m != ret_n) || !mode_ok) begin
                        trap_o = 1'b1;
                        kind_o = TK_ILLEGAL;
                    end else begin
                        base_nxt_o = base_i - BW'(ret_n);
                        if (behind_i[ret_n - 2'd1]) begin
                            clr_old_o = 1'b1;
                        end else begin
                            save_o = 1'b1;
                            trap_o = 1'b1;
                            kind_o = trap_kind_e'(4'd3 + {2'd0, ret_n});
                        end
                    end
                end
                OP_ROTATE:  base_nxt_o = base_i + rot_ext[BW-1:0];
                OP_RESTORE: base_nxt_o = saved_i;
                OP_MOVSP: begin
                    if (behind_i == 3'b000) begin
                        trap_o = 1'b1;
                        kind_o = TK_ALLOCA;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/regwin_state.sv
// Holds the base, start bitmap, saved base and busy flag.
// Applies the edits chosen by the decision logic at the clock edge.
module regwin_state #(
    parameter int FRAMES = 16,
    localparam int BW    = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_go_i,
    input  logic [BW-1:0]     base_nxt_i,
    input  logic              set_new_i,
    input  logic              clr_old_i,
    input  logic              save_i,
    input  logic              trap_i,
    input  logic              ack_i,
    output logic [BW-1:0]     base_o,
    output logic [FRAMES-1:0] start_o,
    output logic [BW-1:0]     saved_o,
    output logic              busy_o
);

    // Window base register.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_o <= '0;
        else if (op_go_i) base_o <= base_nxt_i;
    end

    // Start bitmap: set the new frame on entry, clear the old one on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o <= FRAMES'(1);
        end else if (op_go_i) begin
            if (set_new_i) start_o[base_nxt_i] <= 1'b1;
            if (clr_old_i) start_o[base_o]     <= 1'b0;
        end
    end

    // Saved base, written on overflow and underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)                 saved_o <= '0;
        else if (op_go_i && save_i) saved_o <= base_o;
    end

    // Busy flag, raised by a trap and dropped by an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_o <= 1'b0;
        else if (trap_i) busy_o <= 1'b1;
        else if (ack_i)  busy_o <= 1'b0;
    end

endmodule

// File: rtl/regwin_ctrl.sv
// Register window controller top. Ties the scan, decision and state pieces
// together. NUM_REGS must be four times a power of two, and at least 16.
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int NUM_REGS = 64,
    localparam int FRAMES  = NUM_REGS / 4,
    localparam int BW      = $clog2(FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [2:0]        op_code_i,
    input  logic [3:0]        op_imm_i,
    input  logic [1:0]        callinc_i,
    input  logic              woe_i,
    input  logic              excm_i,
    input  logic [31:0]       ra_i,
    input  logic [31:0]       pc_i,
    input  logic              trap_ack_i,
    output logic              busy_o,
    output logic [BW-1:0]     base_o,
    output logic [BW-1:0]     base_next_o,
    output logic [BW-1:0]     saved_base_o,
    output logic [FRAMES-1:0] start_o,
    output logic              trap_o,
    output logic [3:0]        trap_kind_o,
    output logic [31:0]       ret_pc_o
);

    logic       op_go;
    logic [4:0] ahead;
    logic [2:0] behind;
    logic       set_new;
    logic       clr_old;
    logic       save;
    trap_kind_e kind;

    // An operation is accepted only while no trap is outstanding.
    assign op_go       = op_valid_i & ~busy_o;
    assign trap_kind_o = kind;

    regwin_scan #(.FRAMES(FRAMES)) u_scan (
        .start_i  (start_o),
        .base_i   (base_o),
        .ahead_o  (ahead),
        .behind_o (behind)
    );

    regwin_decide #(.FRAMES(FRAMES)) u_decide (
        .op_go_i    (op_go),
        .op_code_i  (op_code_i),
        .op_imm_i   (op_imm_i),
        .callinc_i  (callinc_i),
        .woe_i      (woe_i),
        .excm_i     (excm_i),
        .ra_i       (ra_i),
        .pc_i       (pc_i),
        .base_i     (base_o),
        .saved_i    (saved_base_o),
        .ahead_i    (ahead),
        .behind_i   (behind),
        .base_nxt_o (base_next_o),
        .set_new_o  (set_new),
        .clr_old_o  (clr_old),
        .save_o     (save),
        .trap_o     (trap_o),
        .kind_o     (kind),
        .ret_pc_o   (ret_pc_o)
    );

    regwin_state #(.FRAMES(FRAMES)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_go_i    (op_go),
        .base_nxt_i (base_next_o),
        .set_new_i  (set_new),
        .clr_old_i  (clr_old),
        .save_i     (save),
        .trap_i     (trap_o),
        .ack_i      (trap_ack_i),
        .base_o     (base_o),
        .start_o    (start_o),
        .saved_o    (saved_base_o),
        .busy_o     (busy_o)
    );

endmodule

// File: rtl/regwin_ctrl_chk.sv
// Property checker for the register window controller, bound to the top.
module regwin_ctrl_chk #(
    parameter int NUM_REGS = 64,
    localparam int FRAMES  = NUM_REGS / 4,
    localparam int BW      = $clog2(FRAMES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid_i,
    input logic [2:0]        op_code_i,
    input logic [31:0]       ra_i,
    input logic [31:0]       pc_i,
    input logic              busy_o,
    input logic [BW-1:0]     base_o,
    input logic [BW-1:0]     base_next_o,
    input logic [BW-1:0]     saved_base_o,
    input logic [FRAMES-1:0] start_o,
    input logic              trap_o,
    input logic [3:0]        trap_kind_o,
    input logic [31:0]       ret_pc_o
);

    logic go;
    assign go = op_valid_i && !busy_o;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (base_o == '0 && saved_base_o == '0 && start_o == FRAMES'(1) && !busy_o));

    p_base_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> base_o == $past(base_next_o));

    p_illegal_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && trap_kind_o == 4'd7) |=> ($stable(base_o) && $stable(start_o) && $stable(saved_base_o)));

    p_ovf_saves_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && trap_kind_o >= 4'd1 && trap_kind_o <= 4'd3) |=> saved_base_o == $past(base_o));

    p_ret_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_code_i == 3'd2 && !trap_o) |->
            (ret_pc_o[31:30] == pc_i[31:30] && ret_pc_o[29:0] == ra_i[29:0]));

    p_start_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_o != '0);

    p_unf_saves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_o && trap_kind_o >= 4'd4 && trap_kind_o <= 4'd6) |=>
            (saved_base_o == $past(base_o) && $stable(start_o)));

    p_movsp_still_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_code_i == 3'd5) |-> base_next_o == base_o);

    p_trap_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> busy_o);

    p_busy_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !trap_o);

    p_busy_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(base_o) && $stable(start_o) && $stable(saved_base_o)));

endmodule

bind regwin_ctrl regwin_ctrl_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid_i   (op_valid_i),
    .op_code_i    (op_code_i),
    .ra_i         (ra_i),
    .pc_i         (pc_i),
    .busy_o       (busy_o),
    .base_o       (base_o),
    .base_next_o  (base_next_o),
    .saved_base_o (saved_base_o),
    .start_o      (start_o),
    .trap_o       (trap_o),
    .trap_kind_o  (trap_kind_o),
    .ret_pc_o     (ret_pc_o)
);

// File: tb/regwin_ctrl_tb_top.sv
// Bench for the register window controller: a behavioural reference model
// compared with the outputs every cycle.
module regwin_ctrl_tb_top;

    localparam int NREG = 64;
    localparam int F    = NREG / 4;
    localparam int BW   = $clog2(F);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid_i = 1'b0;
    logic [2:0]    op_code_i = '0;
    logic [3:0]    op_imm_i = '0;
    logic [1:0]    callinc_i = '0;
    logic          woe_i = 1'b1;
    logic          excm_i = 1'b0;
    logic [31:0]   ra_i = '0;
    logic [31:0]   pc_i = '0;
    logic          trap_ack_i = 1'b0;
    logic          busy_o;
    logic [BW-1:0] base_o;
    logic [BW-1:0] base_next_o;
    logic [BW-1:0] saved_base_o;
    logic [F-1:0]  start_o;
    logic          trap_o;
    logic [3:0]    trap_kind_o;
    logic [31:0]   ret_pc_o;

    always #2 clk = ~clk;

    regwin_ctrl #(.NUM_REGS(NREG)) dut_i (.*);

    int     n_checks = 0;
    int     n_fail   = 0;
    bit     finished = 0;
    int     m_base, m_saved;
    bit     m_busy;
    bit     m_ws[F];
    string  state_tag = "R1";

    function automatic int wrapf(int v);
        return ((v % F) + F) % F;
    endfunction

    function automatic int model_start();
        int v = 0;
        for (int i = 0; i < F; i++) if (m_ws[i]) v |= (1 << i);
        return v;
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_state();
        chk(int'(base_o) == m_base, state_tag, "base", base_o, m_base);
        chk(int'(start_o) == model_start(), state_tag, "start", start_o, model_start());
        chk(int'(saved_base_o) == m_saved, state_tag, "saved", saved_base_o, m_saved);
        chk(busy_o == m_busy, state_tag, "busy", busy_o, m_busy);
    endtask

    // One cycle: check registered state, drive, check comb outputs, advance model.
    task automatic step(bit v, int code, int imm, int ci, bit w, bit x,
                        logic [31:0] ra, logic [31:0] pc, bit ack);
        bit    go, et, nws[F];
        int    ek, nb, nsav, hit, n, m, d;
        string tag;
        @(negedge clk);
        check_state();
        op_valid_i = v; op_code_i = 3'(code); op_imm_i = 4'(imm);
        callinc_i = 2'(ci); woe_i = w; excm_i = x; ra_i = ra; pc_i = pc;
        trap_ack_i = ack;
        #1;
        go = v && !m_busy;
        et = 0; ek = 0; nb = m_base; nsav = m_saved; nws = m_ws;
        tag = go ? "R13" : (m_busy ? "R13" : "R13");
        if (go) begin
            case (code)
                1: begin
                    if (imm > 3 || !(w && !x)) begin
                        et = 1; ek = 7; tag = "R3";
                    end else begin
                        hit = -1;
                        for (int k = 1; k <= ci; k++) if (hit < 0 && m_ws[wrapf(m_base + k)]) hit = k;
                        if (hit >= 0) begin
                            nb = wrapf(m_base + hit); nsav = m_base; et = 1; tag = "R5";
                            ek = m_ws[wrapf(m_base + hit + 1)] ? 1 :
                                 (m_ws[wrapf(m_base + hit + 2)] ? 2 : 3);
                        end else begin
                            nb = wrapf(m_base + ci); nws[nb] = 1; tag = "R4";
                        end
                    end
                end
                2: begin
                    n = int'(ra[31:30]); m = 0;
                    for (int k = 3; k >= 1; k--) if (m_ws[wrapf(m_base - k)]) m = k;
                    if (n == 0 || (m != 0 && m != n) || !(w && !x)) begin
                        et = 1; ek = 7; tag = "R6";
                    end else begin
                        chk(ret_pc_o == {pc[31:30], ra[29:0]}, "R7", "ret_pc",
                            ret_pc_o, {pc[31:30], ra[29:0]});
                        nb = wrapf(m_base - n);
                        if (m_ws[nb]) begin
                            nws[m_base] = 0; tag = "R8";
                        end else begin
                            et = 1; ek = 3 + n; nsav = m_base; tag = "R9";
                        end
                    end
                end
                3: begin
                    d = (imm >= 8) ? imm - 16 : imm;
                    nb = wrapf(m_base + d); tag = "R2 R10";
                end
                4: begin nb = m_saved; tag = "R11"; end
                5: begin
                    tag = "R12";
                    if (!m_ws[wrapf(m_base - 1)] && !m_ws[wrapf(m_base - 2)] && !m_ws[wrapf(m_base - 3)]) begin
                        et = 1; ek = 8;
                    end
                end
                default: ;
            endcase
        end
        chk(trap_o == et, tag, "trap", trap_o, et);
        chk(int'(trap_kind_o) == ek, tag, "kind", trap_kind_o, ek);
        chk(int'(base_next_o) == nb, tag, "base_next", base_next_o, nb);
        m_base = nb; m_saved = nsav; m_ws = nws;
        if (et) m_busy = 1;
        else if (m_busy && ack) m_busy = 0;
        state_tag = tag;
    endtask

    task automatic ack_step();
        step(0, 0, 0, 0, 1, 0, 32'h0, 32'h0, 1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        m_base = 0; m_saved = 0; m_busy = 0;
        for (int i = 0; i < F; i++) m_ws[i] = (i == 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state is checked by the first step.
        step(0, 0, 0, 0, 1, 0, 0, 0, 0);
        // R4: legal entries with increments 1, 2, 3.
        step(1, 1, 1, 1, 1, 0, 0, 32'h100, 0);
        step(1, 1, 2, 2, 1, 0, 0, 32'h104, 0);
        step(1, 1, 0, 3, 1, 0, 0, 32'h108, 0);
        // R3: illegal entries, each acknowledged; R13 busy ignores a strobe.
        step(1, 1, 5, 1, 1, 0, 0, 0, 0);
        step(1, 3, 2, 0, 1, 0, 0, 0, 0);
        ack_step();
        step(1, 1, 1, 1, 0, 0, 0, 0, 0);
        ack_step();
        step(1, 1, 1, 1, 1, 1, 0, 0, 0);
        ack_step();
        // R6/R7/R8: returns.
        step(1, 2, 0, 0, 1, 0, {2'd3, 30'h0000_1234}, 32'hC000_0000, 0);
        step(1, 2, 0, 0, 1, 0, {2'd2, 30'h0000_0020}, 32'h4000_0000, 0);
        step(1, 2, 0, 0, 1, 0, {2'd0, 30'h1}, 0, 0);
        ack_step();
        step(1, 2, 0, 0, 1, 0, {2'd3, 30'h1}, 0, 0);
        ack_step();
        step(1, 2, 0, 0, 1, 0, {2'd1, 30'h3FFF_FFFF}, 32'h8000_0000, 0);
        // R12: stack-move check fails at base 0 with only frame 0 live.
        step(1, 5, 0, 0, 1, 0, 0, 0, 0);
        ack_step();
        // R9: underflow after rotating away.
        step(1, 3, 4, 0, 1, 0, 0, 0, 0);
        step(1, 2, 0, 0, 1, 0, {2'd1, 30'h0}, 0, 0);
        ack_step();
        // R11/R10/R2: restore and rotations wrapping.
        step(1, 4, 0, 0, 1, 0, 0, 0, 0);
        step(1, 3, 15, 0, 1, 0, 0, 0, 0);
        step(1, 3, 11, 0, 1, 0, 0, 0, 0);
        step(1, 3, 7, 0, 1, 0, 0, 0, 0);
        step(1, 3, 10, 0, 1, 0, 0, 0, 0);
        // R5: overflow 12 from base 15 with frame 0 live.
        step(1, 1, 0, 3, 1, 0, 0, 0, 0);
        ack_step();
        // R13: op codes 6 and 7 do nothing.
        step(1, 6, 0, 0, 1, 0, 0, 0, 0);
        step(1, 7, 0, 0, 1, 0, 0, 0, 0);
        // Mixed random stream.
        for (int i = 0; i < 3000; i++) begin
            int c = $urandom_range(0, 7);
            if (c >= 6) c = ($urandom_range(0, 1) == 1) ? 1 : 2;
            step($urandom_range(0, 9) != 0, c, $urandom_range(0, 15),
                 $urandom_range(0, 3), $urandom_range(0, 15) != 0,
                 $urandom_range(0, 15) == 0, $urandom, $urandom,
                 $urandom_range(0, 2) == 0);
        end
        step(0, 0, 0, 0, 1, 0, 0, 0, 1);
        @(negedge clk);
        check_state();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule